// File: doc/BRIEF.md
# UART Receive Character Buffer with Line Status

This block sits between a UART receive shifter and the bus. The shifter hands over each fully assembled character together with a flag that marks a bad parity bit. The block stores the character in a first-in, first-out buffer whose depth is a parameter. The bus side has two plain read strobes. One pops the oldest character into a held output register. The other reads a three-bit status word that reports data-ready, overrun and parity error.

The character input is a valid/ready stream, but the shifter cannot stall. `rx_ready` only warns that the buffer is full. A character offered while `rx_ready` is low is discarded, the stored characters stay as they are, and the overrun bit is set.

The overrun and parity bits are sticky and clear when the status word is read. The parity bit follows the character at the buffer head, not the newest arrival. Each entry keeps its own parity flag. The status bit is latched when an erroneous entry becomes the head.

Top module: `rx_stat_fifo`

## Requirements
- R1: After reset, `stat_out` is 3'b000, `rx_ready` is 1 and `char_out` is 0.
- R2: Characters leave in arrival order, and `char_out` shows the popped character from the clock edge that takes the `char_pop` strobe onward.
- R3: Bit 0 of `stat_out` (data-ready) is 1 exactly while at least one unread character is stored.
- R4: `rx_ready` is 0 exactly while the buffer holds DEPTH characters.
- R5: A character offered while the buffer is full is dropped, the stored characters are kept, and bit 1 of `stat_out` (overrun) is 1 from the next edge.
- R6: A `stat_read` strobe returns the current `stat_out` value, and it clears bits 1 and 2 at that edge unless a new event sets them in the same cycle.
- R7: Bit 2 of `stat_out` (parity error) becomes 1 at the edge where a character with its parity flag set becomes the buffer head. This happens either by a push into an empty buffer or by a pop that exposes it.
- R8: Once set, the parity bit stays 1 after the bad character is popped, until a status read clears it.
- R9: When an overrun or parity event occurs in the same cycle as a status read, the affected bit is 1 after that edge.
- R10: A `char_pop` strobe while the buffer is empty leaves `char_out` and the stored count unchanged.
- R11: A character with a bad parity flag that is not at the head does not set bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Assembled character offered by the shifter |
| rx_ready | output | 1 | Buffer not full; low means an offer is dropped |
| rx_char | input | DW | Assembled character |
| rx_perr | input | 1 | Parity of this character was wrong |
| char_pop | input | 1 | Pop the oldest character into `char_out` |
| char_out | output | DW | Last popped character (held) |
| stat_read | input | 1 | Status read strobe; clears sticky bits |
| stat_out | output | 3 | {parity error, overrun, data-ready} |

## Verification
A wrong count or pointer shows up at the ports within one pop or push. The data-ready bit or `rx_ready` flips at the wrong fill level, or `char_out` returns a character out of order. A parity flag stored against the wrong entry makes bit 2 rise one edge too early or too late while the buffer drains. A lost sticky update makes bit 1 or 2 disagree with the expected value right after the overrun, the pop or the status read that should have moved it. The bench sweeps every fill level, including overfill, over several parity patterns, which catches each of these at the first cycle it occurs.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  localparam int STAT_W = 3;
  localparam int BIT_RDY = 0;
  localparam int BIT_OVR = 1;
  localparam int BIT_PAR = 2;

  typedef struct packed {
    logic       perr;
    logic [7:0] data;
  } ent_t;
endpackage

// File: rtl/rxsf_store.sv
module rxsf_store #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_perr,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          full,
  output logic          empty,
  output logic          cnt_one,
  output logic          nxt_perr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_d [DEPTH];
  logic          mem_p [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, nxt_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign cnt_one = (count == CW'(1));
  assign push_ok = push && !full;
  assign pop_ok  = pop_req && !empty;
  assign nxt_ptr = bump(rd_ptr);
  assign nxt_perr = mem_p[nxt_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_d[wr_ptr] <= push_data;
      mem_p[wr_ptr] <= push_perr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok) begin
        rd_ptr  <= nxt_ptr;
        rd_data <= mem_d[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop_req) |=> $stable(count));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push) |=> ($stable(rd_data) && $stable(count)));
endmodule

// File: rtl/rxsf_flags.sv
module rxsf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic par_evt,
  input  logic clr,
  output logic ovr_q,
  output logic par_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      ovr_q <= ovr_evt | (ovr_q & ~clr);
      par_q <= par_evt | (par_q & ~clr);
    end
  end

  // R9
  ovr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ovr_evt) |=> ovr_q);

  // R6
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovr_evt && !par_evt) |=> (!ovr_q && !par_q));
endmodule

// File: rtl/rx_stat_fifo.sv
module rx_stat_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_perr,
  input  logic          char_pop,
  output logic [DW-1:0] char_out,
  input  logic          stat_read,
  output logic [2:0]    stat_out
);
  import rxsf_pkg::*;

  logic push_ok, pop_ok, full, empty, cnt_one, nxt_perr;
  logic ovr_q, par_q, ovr_evt, par_evt;

  rxsf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .push_data(rx_char), .push_perr(rx_perr),
    .pop_req(char_pop), .push_ok(push_ok), .pop_ok(pop_ok),
    .full(full), .empty(empty), .cnt_one(cnt_one),
    .nxt_perr(nxt_perr), .rd_data(char_out)
  );

  assign ovr_evt = rx_valid && full;
  // a flagged entry reaches the head: into empty, replacing a lone head, or exposed by a pop
  assign par_evt = (push_ok && rx_perr && (empty || (cnt_one && pop_ok)))
                || (pop_ok && !cnt_one && nxt_perr);

  rxsf_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ovr_evt(ovr_evt), .par_evt(par_evt), .clr(stat_read),
    .ovr_q(ovr_q), .par_q(par_q)
  );

  assign rx_ready = !full;
  always_comb begin
    stat_out = '0;
    stat_out[BIT_RDY] = !empty;
    stat_out[BIT_OVR] = ovr_q;
    stat_out[BIT_PAR] = par_q;
  end

  // R5
  ovr_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> stat_out[1]);

  // R7
  head_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_perr && !stat_out[0]) |=> stat_out[2]);

  // R3
  rdy_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> stat_out[0]);
endmodule

// File: tb/rx_stat_fifo_bench.sv
module rx_stat_fifo_bench;
  localparam int D = 4;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_perr = 0, char_pop = 0, stat_read = 0;
  logic [7:0] rx_char = 0;
  logic rx_ready;
  logic [7:0] char_out;
  logic [2:0] stat_out;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  rx_stat_fifo #(.DEPTH(D), .DW(8)) u_rx_stat_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_char(rx_char), .rx_perr(rx_perr), .char_pop(char_pop),
    .char_out(char_out), .stat_read(stat_read), .stat_out(stat_out)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] dval(int n, int p, int i);
    return 8'(n * 16 + i * 3 + p * 64 + 1);
  endfunction

  function automatic bit pval(int p, int i);
    return ((i + p) % 3) == 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] last;
    bit pe;
    int acc;
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1;
    @(negedge clk);
    chk("R1 stat", int'(stat_out), 0);
    chk("R1 ready", int'(rx_ready), 1);
    chk("R1 data", int'(char_out), 0);
    last = 0;

    for (int n = 0; n <= D + 2; n++) begin
      for (int p = 0; p < 3; p++) begin
        stat_read = 1; cyc(); stat_read = 0;
        acc = (n < D) ? n : D;
        for (int i = 0; i < n; i++) begin
          rx_valid = 1; rx_char = dval(n, p, i); rx_perr = pval(p, i);
          cyc();
        end
        rx_valid = 0; rx_perr = 0;
        chk("R4 ready", int'(rx_ready), int'(acc < D));
        chk("R3 data-ready", int'(stat_out[0]), int'(acc > 0));
        chk("R5 overrun", int'(stat_out[1]), int'(n > D));
        chk("R7 R11 parity at head", int'(stat_out[2]), int'(acc > 0 && pval(p, 0)));
        stat_read = 1;
        cyc();
        stat_read = 0;
        chk("R6 clear ovr", int'(stat_out[1]), 0);
        chk("R6 clear par", int'(stat_out[2]), 0);
        pe = 0;
        for (int i = 0; i < acc; i++) begin
          char_pop = 1; cyc(); char_pop = 0;
          if (i + 1 < acc && pval(p, i + 1)) pe = 1;
          last = dval(n, p, i);
          chk("R2 order", int'(char_out), int'(last));
          chk("R3 drain", int'(stat_out[0]), int'(i + 1 < acc));
          chk("R8 parity sticky", int'(stat_out[2]), int'(pe));
        end
        char_pop = 1; cyc(); char_pop = 0;
        chk("R10 empty pop data", int'(char_out), int'(last));
        chk("R10 empty pop rdy", int'(stat_out[0]), 0);
      end
    end

    stat_read = 1; cyc();
    rx_valid = 1; rx_char = 8'hA5; rx_perr = 1;
    cyc();
    rx_valid = 0; rx_perr = 0; stat_read = 0;
    chk("R9 parity wins", int'(stat_out), 5);
    stat_read = 1; cyc(); stat_read = 0;
    chk("R6 read clears", int'(stat_out), 1);
    for (int i = 0; i < D - 1; i++) begin
      rx_valid = 1; rx_char = 8'(i + 16); cyc();
    end
    chk("R4 full", int'(rx_ready), 0);
    rx_valid = 1; rx_char = 8'hEE; stat_read = 1;
    cyc();
    rx_valid = 0; stat_read = 0;
    chk("R9 overrun wins", int'(stat_out), 3);
    char_pop = 1; cyc();
    chk("R5 kept head", int'(char_out), 8'hA5);
    for (int i = 0; i < D - 1; i++) begin
      cyc();
      chk("R5 kept rest", int'(char_out), i + 16);
    end
    char_pop = 0;
    chk("R3 empty", int'(stat_out[0]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule